// File: doc/BRIEF.md
# Duty-Cycle Clock Throttle Generator

This block slows a processor for passive cooling. It repeats a request for the processor to stop its clock, and it asserts that request for a programmable share of a fixed period. The period is `2**PERIOD_LOG2` clocks, which is 1024 by default. The share is set in eighths of the period by a 3-bit duty code.

Two enables start throttling. The normal enable uses the normal duty field. The forced enable uses its own duty field and wins when both enables are set. After the request goes low, the active time is not counted until the processor acknowledges with stop-grant. A late acknowledgement therefore lengthens the low phase and does not shorten the granted stop time. Clearing both enables releases the request on the next edge and returns the block to idle.

Top module: `throttle_gen`

## Requirements
- R1: With both enables low, `stop_req_n` is 1. This holds from reset. If both enables are sampled low on an edge, `stop_req_n` is 1 after that edge. The period counter is cleared, so a later enable starts a fresh period whose low phase has the full length.
- R2: Either enable alone starts throttling. On the edge after an enable is first sampled high from idle, `stop_req_n` goes to 0.
- R3: Let STEP = PERIOD/8. With `stop_ack` held at 1, a duty code n from 1 to 7 keeps `stop_req_n` low for exactly n×STEP clocks in each period.
- R4: Duty code 0 gives the same low time as code 4, which is 4×STEP clocks.
- R5: When `force_en` is 1, the duty comes from `duty_force` and `duty_norm` is ignored. Otherwise the duty comes from `duty_norm`.
- R6: While `stop_ack` is 0, the request stays low and the active-time count does not advance. The edge that first samples `stop_ack` at 1 counts as the first active clock. After that edge, the request stays low for exactly (active time − 1) more clocks.
- R7: The high phase of each period lasts PERIOD − active time clocks. With `stop_ack` held at 1, a new low phase starts every PERIOD clocks.
- R8: A change to a duty field during a period does not alter that period. The new value takes effect from the next low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all counts are in these cycles |
| rst_n | input | 1 | Asynchronous reset, active low |
| thr_en | input | 1 | Normal throttle enable |
| force_en | input | 1 | Forced throttle enable; takes priority over `thr_en` |
| duty_norm | input | DUTY_W (3) | Duty code used under normal throttling |
| duty_force | input | DUTY_W (3) | Duty code used under forced throttling |
| stop_ack | input | 1 | Stop-grant acknowledgement from the processor |
| stop_req_n | output | 1 | Stop-clock request, active low |

## Verification
The bench builds the block with `PERIOD_LOG2 = 6`, so a period is 64 clocks and one duty step is 8 clocks. At this size every duty code, the code-0 mapping and a full period boundary take only a few dozen cycles. That makes it possible to measure the exact low and high widths over several consecutive periods. It is also possible to hold the acknowledgement off for far longer than a period and then count the remaining low cycles. The duty width stays at its default of 3, so the decoding of codes and the step size follow the same rules as the full-size build.

// File: rtl/thr_pkg.sv
package thr_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_ON   = 2'd2,
      ST_OFF  = 2'd3
   } thr_state_e;

   function automatic logic req_low(input thr_state_e s);
      return (s == ST_WAIT) || (s == ST_ON);
   endfunction

endpackage

// File: rtl/thr_duty_sel.sv
module thr_duty_sel #(
   parameter int DUTY_W       = 3,
   parameter int LEN_W        = 10,
   parameter int STEP         = 128,
   parameter bit ZERO_AS_HALF = 1'b1
) (
   input  logic              force_en,
   input  logic [DUTY_W-1:0] duty_norm,
   input  logic [DUTY_W-1:0] duty_force,
   output logic [LEN_W-1:0]  on_len
);

   localparam logic [DUTY_W-1:0] HALF_CODE = DUTY_W'(1) << (DUTY_W - 1);
   localparam logic [DUTY_W-1:0] LOW_CODE  = DUTY_W'(1);

   logic [DUTY_W-1:0] code_sel;
   logic [DUTY_W-1:0] code_eff;

   if (DUTY_W < 2) begin : g_bad_duty_w
      $error("thr_duty_sel: DUTY_W must be at least 2");
   end

   // R5: the forced field wins whenever the forced enable is set
   always_comb code_sel = force_en ? duty_force : duty_norm;

   if (ZERO_AS_HALF) begin : g_zero_half
      // R4: code zero behaves as the half-period code
      always_comb code_eff = (code_sel == '0) ? HALF_CODE : code_sel;
   end else begin : g_zero_low
      always_comb code_eff = (code_sel == '0) ? LOW_CODE : code_sel;
   end

   always_comb on_len = LEN_W'(code_eff) * LEN_W'(STEP);

endmodule

// File: rtl/thr_period_ctr.sv
module thr_period_ctr #(
   parameter int W = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         one,
   input  logic         inc,
   output logic [W-1:0] cnt
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (one) cnt <= W'(1);
      else if (inc) cnt <= cnt + 1'b1;
   end

   // R7: the count never wraps within a phase
   p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !clr && !one) |-> (cnt != '1));

endmodule

// File: rtl/thr_seq.sv
module thr_seq
   import thr_pkg::*;
#(
   parameter int W = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         ack,
   input  logic [W-1:0] cnt,
   input  logic [W-1:0] on_len,
   input  logic [W-1:0] off_len,
   output thr_state_e   state,
   output thr_state_e   state_nxt,
   output logic         ctr_clr,
   output logic         ctr_one,
   output logic         ctr_inc,
   output logic         load_len
);

   logic on_last;
   logic off_last;

   always_comb on_last  = (cnt == on_len  - 1'b1);
   always_comb off_last = (cnt == off_len - 1'b1);

   always_comb begin
      state_nxt = state;
      ctr_clr   = 1'b0;
      ctr_one   = 1'b0;
      ctr_inc   = 1'b0;
      load_len  = 1'b0;
      if (!run) begin
         // R1: leave throttling at once and clear the count
         state_nxt = ST_IDLE;
         ctr_clr   = 1'b1;
      end else begin
         unique case (state)
            ST_IDLE: begin
               state_nxt = ST_WAIT;
               ctr_clr   = 1'b1;
               load_len  = 1'b1;
            end
            ST_WAIT: begin
               // R6: the acknowledging edge is the first active clock
               if (ack) begin
                  state_nxt = ST_ON;
                  ctr_one   = 1'b1;
               end
            end
            ST_ON: begin
               if (on_last) begin
                  state_nxt = ST_OFF;
                  ctr_clr   = 1'b1;
               end else begin
                  ctr_inc = 1'b1;
               end
            end
            ST_OFF: begin
               if (off_last) begin
                  state_nxt = ST_WAIT;
                  ctr_clr   = 1'b1;
                  load_len  = 1'b1;
               end else begin
                  ctr_inc = 1'b1;
               end
            end
            default: begin
               state_nxt = ST_IDLE;
               ctr_clr   = 1'b1;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= state_nxt;
   end

   p_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (state == ST_IDLE));

   p_hold_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT && !ack && run) |=> (state == ST_WAIT) && $stable(cnt));

   p_on_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ON) |-> (cnt < on_len));

   p_off_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_OFF) |-> (cnt < off_len));

endmodule

// File: rtl/throttle_gen.sv
module throttle_gen
   import thr_pkg::*;
#(
   parameter int PERIOD_LOG2  = 10,
   parameter int DUTY_W       = 3,
   parameter bit ZERO_AS_HALF = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              thr_en,
   input  logic              force_en,
   input  logic [DUTY_W-1:0] duty_norm,
   input  logic [DUTY_W-1:0] duty_force,
   input  logic              stop_ack,
   output logic              stop_req_n
);

   localparam int PERIOD = 1 << PERIOD_LOG2;
   localparam int STEP   = PERIOD >> DUTY_W;
   localparam int W      = PERIOD_LOG2;

   if (PERIOD_LOG2 <= DUTY_W) begin : g_bad_period
      $error("throttle_gen: PERIOD_LOG2 must exceed DUTY_W");
   end

   thr_state_e state;
   thr_state_e state_nxt;
   logic       run;
   logic       ctr_clr;
   logic       ctr_one;
   logic       ctr_inc;
   logic       load_len;
   logic [W-1:0] cnt;
   logic [W-1:0] on_len_sel;
   logic [W-1:0] on_len_q;
   logic [W-1:0] off_len;
   logic         req_n_q;

   always_comb run = thr_en | force_en;

   thr_duty_sel #(
      .DUTY_W       (DUTY_W),
      .LEN_W        (W),
      .STEP         (STEP),
      .ZERO_AS_HALF (ZERO_AS_HALF)
   ) u_sel (
      .force_en   (force_en),
      .duty_norm  (duty_norm),
      .duty_force (duty_force),
      .on_len     (on_len_sel)
   );

   // R8: the active length is captured only when a period begins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        on_len_q <= '0;
      else if (load_len) on_len_q <= on_len_sel;
   end

   // R7: the high phase fills the rest of the period (modulo 2**W)
   always_comb off_len = W'(0) - on_len_q;

   thr_period_ctr #(.W(W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (ctr_clr),
      .one   (ctr_one),
      .inc   (ctr_inc),
      .cnt   (cnt)
   );

   thr_seq #(.W(W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .ack       (stop_ack),
      .cnt       (cnt),
      .on_len    (on_len_q),
      .off_len   (off_len),
      .state     (state),
      .state_nxt (state_nxt),
      .ctr_clr   (ctr_clr),
      .ctr_one   (ctr_one),
      .ctr_inc   (ctr_inc),
      .load_len  (load_len)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_n_q <= 1'b1;
      else        req_n_q <= !req_low(state_nxt);
   end

   always_comb stop_req_n = req_n_q;

   p_out_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> stop_req_n);

   p_len_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !load_len |=> $stable(on_len_q));

   p_len_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE) |-> (on_len_q >= W'(STEP)) && (on_len_q <= W'(PERIOD - STEP)));

   p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && run) |=> !stop_req_n);

endmodule

// File: tb/throttle_gen_tb.sv
module throttle_gen_tb;

   localparam int PL     = 6;
   localparam int PERIOD = 1 << PL;
   localparam int STEP   = PERIOD / 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       thr_en = 1'b0;
   logic       force_en = 1'b0;
   logic [2:0] duty_norm = 3'd0;
   logic [2:0] duty_force = 3'd0;
   logic       stop_ack = 1'b1;
   logic       stop_req_n;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   throttle_gen #(.PERIOD_LOG2(PL), .DUTY_W(3), .ZERO_AS_HALF(1'b1)) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .thr_en     (thr_en),
      .force_en   (force_en),
      .duty_norm  (duty_norm),
      .duty_force (duty_force),
      .stop_ack   (stop_ack),
      .stop_req_n (stop_req_n)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   // called at a negedge; returns at the negedge that opens the next low phase
   task automatic measure(output int lo, output int hi);
      while (stop_req_n !== 1'b0) @(negedge clk);
      lo = 0;
      while (stop_req_n === 1'b0) begin lo++; @(negedge clk); end
      hi = 0;
      while (stop_req_n === 1'b1) begin hi++; @(negedge clk); end
   endtask

   task automatic go_idle();
      thr_en   = 1'b0;
      force_en = 1'b0;
      stop_ack = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset();
      chk(stop_req_n === 1'b1, "R1 reset level", int'(stop_req_n), 1);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(stop_req_n === 1'b1, "R1 idle level", int'(stop_req_n), 1);
   endtask

   task automatic t_duty(input logic [2:0] code, input int exp_lo, input string req);
      int lo, hi;
      duty_norm = code;
      thr_en    = 1'b1;
      @(negedge clk);
      chk(stop_req_n === 1'b0, "R2 start after enable", int'(stop_req_n), 0);
      for (int k = 0; k < 2; k++) begin
         measure(lo, hi);
         chk(lo == exp_lo, req, lo, exp_lo);
         chk(hi == PERIOD - exp_lo, "R7 high phase", hi, PERIOD - exp_lo);
      end
      go_idle();
   endtask

   task automatic t_force();
      int lo, hi;
      duty_norm  = 3'd1;
      duty_force = 3'd6;
      thr_en     = 1'b1;
      force_en   = 1'b1;
      measure(lo, hi);
      chk(lo == 6 * STEP, "R5 forced field wins", lo, 6 * STEP);
      go_idle();
      duty_force = 3'd3;
      force_en   = 1'b1;
      @(negedge clk);
      chk(stop_req_n === 1'b0, "R2 forced enable alone", int'(stop_req_n), 0);
      measure(lo, hi);
      chk(lo == 3 * STEP, "R5 forced duty alone", lo, 3 * STEP);
      go_idle();
   endtask

   task automatic t_wait_ack();
      int rest, hi, bad;
      stop_ack  = 1'b0;
      duty_norm = 3'd2;
      thr_en    = 1'b1;
      while (stop_req_n !== 1'b0) @(negedge clk);
      bad = 0;
      for (int k = 0; k < 3 * PERIOD; k++) begin
         if (stop_req_n !== 1'b0) bad++;
         @(negedge clk);
      end
      chk(bad == 0, "R6 held low without ack", bad, 0);
      stop_ack = 1'b1;
      @(negedge clk);
      rest = 0;
      while (stop_req_n === 1'b0) begin rest++; @(negedge clk); end
      chk(rest == 2 * STEP - 1, "R6 low after ack", rest, 2 * STEP - 1);
      hi = 0;
      while (stop_req_n === 1'b1) begin hi++; @(negedge clk); end
      chk(hi == PERIOD - 2 * STEP, "R7 high after late ack", hi, PERIOD - 2 * STEP);
      go_idle();
   endtask

   task automatic t_change();
      int lo, hi;
      duty_norm = 3'd2;
      thr_en    = 1'b1;
      measure(lo, hi);
      duty_norm = 3'd5;
      measure(lo, hi);
      chk(lo == 2 * STEP, "R8 change ignored mid period", lo, 2 * STEP);
      measure(lo, hi);
      chk(lo == 5 * STEP, "R8 change used next period", lo, 5 * STEP);
      go_idle();
   endtask

   task automatic t_disable();
      int bad, lo, hi;
      duty_norm = 3'd4;
      thr_en    = 1'b1;
      while (stop_req_n !== 1'b0) @(negedge clk);
      repeat (3) @(negedge clk);
      thr_en = 1'b0;
      @(negedge clk);
      chk(stop_req_n === 1'b1, "R1 release on disable", int'(stop_req_n), 1);
      bad = 0;
      for (int k = 0; k < 80; k++) begin
         stop_ack = k[0];
         if (stop_req_n !== 1'b1) bad++;
         @(negedge clk);
      end
      chk(bad == 0, "R1 stays idle", bad, 0);
      stop_ack  = 1'b1;
      duty_norm = 3'd1;
      thr_en    = 1'b1;
      measure(lo, hi);
      chk(lo == STEP, "R1 fresh period after re-enable", lo, STEP);
      go_idle();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_duty(3'd1, 1 * STEP, "R3 code 1");
      t_duty(3'd2, 2 * STEP, "R3 code 2");
      t_duty(3'd7, 7 * STEP, "R3 code 7");
      t_duty(3'd0, 4 * STEP, "R4 code 0 as half");
      t_force();
      t_wait_ack();
      t_change();
      t_disable();
      summary();
      $finish;
   end

endmodule